// File: doc/BRIEF.md
# Digital Loss-of-Signal Qualifier

This block decides, for one receive channel of a bipolar line receiver, whether the incoming line carries a usable signal. It watches two views of the line. The first is a strobe in the reference clock domain that marks pulses an external amplitude comparator has accepted. The second is the recovered symbol stream, delivered as a symbol-enable plus a per-symbol pulse-present flag on the same clock.

Loss of signal is raised when the comparator strobe stays silent for a fixed number of reference cycles. It is dropped only after a complete window of recovered symbols shows enough ones and no overlong run of zeros. Declaration and clearing depend on different evidence, which gives the status hysteresis. A squelch output tells the datapath to force recovered data to zero while loss of signal is active, unless the channel's squelch-disable pin is set.

Top module: `los_qualifier`

## Requirements
- R1: After reset is released, `los` is 1 and the absence timer, symbol window, ones count and zero-run tracking all start from zero. The first symbol accepted after reset is symbol 0 of the first window.
- R2: If `amp_pulse` is 0 at 128 consecutive rising clock edges, `los` is 1 from the following edge onward, whatever its previous value.
- R3: An `amp_pulse` of 1 at any edge restarts the absence count. Two stretches of 127 silent edges separated by one pulse do not raise `los`.
- R4: A symbol is counted only at an edge where `sym_en` is 1, and `sym_pulse` is ignored at every other edge. Windows are contiguous blocks of 128 counted symbols, and `los` does not change from window evaluation before the 128th symbol of a window.
- R5: A window clears `los` only if at least 26 of its 128 symbols have `sym_pulse` = 1. When a window ends at edge P, a clearing result makes `los` 0 from edge P+1.
- R6: A window also clears `los` only if its longest run of consecutive zero symbols, counted from the window's first symbol, is shorter than 64. A run of 63 qualifies and a run of 64 does not.
- R7: A window that fails either condition leaves `los` at 1, and the next window starts with the very next counted symbol using fresh counts.
- R8: The window result never sets `los`. Only the absence timer of R2 raises it, so a failing window while `los` is 0 leaves it at 0.
- R9: `squelch` is 1 exactly when `los` is 1 and `squelch_dis` is 0. With `squelch_dis` = 1 it stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock; all state updates on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| amp_pulse | input | 1 | Strobe: an amplitude-qualified pulse was seen this cycle |
| sym_en | input | 1 | Recovered-symbol enable; one symbol per high cycle |
| sym_pulse | input | 1 | Pulse-present flag of the symbol enabled this cycle |
| squelch_dis | input | 1 | 1 keeps recovered data unsquelched regardless of status |
| los | output | 1 | Loss-of-signal status, 1 while the signal is considered lost |
| squelch | output | 1 | Request to force recovered data to zero |

## Verification
On every cycle, the assertions check several things: a completed absence interval is always followed by a raised status, every fall of the status coincides with a passing window result, and every rise coincides with the absence condition. They also check that window results appear only after a counted symbol and that the counters stay in range. Other behaviours show up only in the bench scenarios. These are the exact density and zero-run boundaries (25 against 26 ones, runs of 63 against 64), the edge on which the status changes, the restart of the absence count by a single pulse, and the way window alignment survives idle cycles and failed windows.

// File: rtl/los_pkg.sv
package los_pkg;

    // Outcome of one completed symbol window
    typedef struct packed {
        logic done;   // one-cycle strobe: a window has just completed
        logic pass;   // completed window met density and zero-run limits
    } win_result_t;

endpackage

// File: rtl/los_absence_timer.sv
module los_absence_timer #(
    parameter int LIMIT = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pulse_i,
    output logic absent_o
);
    localparam int CW = $clog2(LIMIT + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_state_t;

    tmr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (pulse_i) begin
            st_d.cnt = '0;
        end else if (st_q.cnt != CW'(LIMIT)) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign absent_o = (st_q.cnt == CW'(LIMIT));

    AST_TIMER_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_i |=> (st_q.cnt == '0)); // R3
    AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CW'(LIMIT)); // R2

endmodule

// File: rtl/los_window_eval.sv
module los_window_eval #(
    parameter int WINDOW   = 128,
    parameter int MIN_ONES = 26,
    parameter int MAX_RUN  = 64
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sym_en_i,
    input  logic                  sym_pulse_i,
    output los_pkg::win_result_t  result_o
);
    localparam int SW = $clog2(WINDOW);
    localparam int OW = $clog2(WINDOW + 1);
    localparam int RW = $clog2(MAX_RUN + 1);

    typedef struct packed {
        logic [SW-1:0] sym_cnt;
        logic [OW-1:0] ones;
        logic [RW-1:0] run;
        logic          run_fail;
        logic          done;
        logic          pass;
    } win_state_t;

    win_state_t    st_d, st_q;
    logic [OW-1:0] ones_nx;
    logic [RW-1:0] run_nx;
    logic          fail_nx;
    logic          last_sym;

    always_comb begin
        st_d     = st_q;
        st_d.done = 1'b0;
        st_d.pass = 1'b0;
        last_sym = (st_q.sym_cnt == SW'(WINDOW - 1));
        ones_nx  = st_q.ones + (sym_pulse_i ? OW'(1) : OW'(0));
        if (sym_pulse_i) begin
            run_nx = '0;
        end else if (st_q.run == RW'(MAX_RUN)) begin
            run_nx = st_q.run;
        end else begin
            run_nx = st_q.run + 1'b1;
        end
        fail_nx = st_q.run_fail || (run_nx == RW'(MAX_RUN));
        if (sym_en_i) begin
            if (last_sym) begin
                st_d.done     = 1'b1;
                st_d.pass     = (ones_nx >= OW'(MIN_ONES)) && !fail_nx;
                st_d.sym_cnt  = '0;
                st_d.ones     = '0;
                st_d.run      = '0;
                st_d.run_fail = 1'b0;
            end else begin
                st_d.sym_cnt  = st_q.sym_cnt + 1'b1;
                st_d.ones     = ones_nx;
                st_d.run      = run_nx;
                st_d.run_fail = fail_nx;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign result_o.done = st_q.done;
    assign result_o.pass = st_q.pass;

    AST_ONES_LE_SYMS: assert property (@(posedge clk) disable iff (!rst_n)
        OW'(st_q.sym_cnt) >= st_q.ones); // R4
    AST_DONE_AFTER_SYM: assert property (@(posedge clk) disable iff (!rst_n)
        sym_en_i && (st_q.sym_cnt != SW'(WINDOW - 1)) |=> !st_q.done); // R4
    AST_WINDOW_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |-> (st_q.sym_cnt == '0) && (st_q.ones == '0)); // R7
    AST_RUN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.run <= RW'(MAX_RUN)); // R6
    AST_PASS_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pass |-> st_q.done); // R5

endmodule

// File: rtl/los_qualifier.sv
module los_qualifier #(
    parameter int REF_LIMIT = 128,
    parameter int WINDOW    = 128,
    parameter int MIN_ONES  = 26,
    parameter int MAX_RUN   = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic amp_pulse,
    input  logic sym_en,
    input  logic sym_pulse,
    input  logic squelch_dis,
    output logic los,
    output logic squelch
);
    typedef struct packed {
        logic los;
    } top_state_t;

    top_state_t           st_d, st_q;
    logic                 absent;
    los_pkg::win_result_t win_res;

    los_absence_timer #(
        .LIMIT (REF_LIMIT)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .pulse_i  (amp_pulse),
        .absent_o (absent)
    );

    los_window_eval #(
        .WINDOW   (WINDOW),
        .MIN_ONES (MIN_ONES),
        .MAX_RUN  (MAX_RUN)
    ) u_window (
        .clk         (clk),
        .rst_n       (rst_n),
        .sym_en_i    (sym_en),
        .sym_pulse_i (sym_pulse),
        .result_o    (win_res)
    );

    always_comb begin
        st_d = st_q;
        if (absent) begin
            st_d.los = 1'b1;
        end else if (win_res.done && win_res.pass) begin
            st_d.los = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.los <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign los     = st_q.los;
    assign squelch = st_q.los & ~squelch_dis;

    AST_DECLARE_ON_ABSENCE: assert property (@(posedge clk) disable iff (!rst_n)
        absent |=> los); // R2
    AST_CLEAR_NEEDS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(los) |-> $past(win_res.done && win_res.pass)); // R5
    AST_RISE_NEEDS_ABSENCE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(los) |-> $past(absent)); // R8
    AST_SQUELCH_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        squelch_dis |-> !squelch); // R9

endmodule

// File: tb/los_qualifier_bench.sv
module los_qualifier_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic amp_pulse = 1'b0;
    logic sym_en = 1'b0;
    logic sym_pulse = 1'b0;
    logic squelch_dis = 1'b0;
    logic los, squelch;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    los_qualifier u_los_qualifier (
        .clk         (clk),
        .rst_n       (rst_n),
        .amp_pulse   (amp_pulse),
        .sym_en      (sym_en),
        .sym_pulse   (sym_pulse),
        .squelch_dis (squelch_dis),
        .los         (los),
        .squelch     (squelch)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0b expected %0b", req, act, exp);
        end
    endtask

    // mode 0: k ones every 4th symbol; mode 1: trailing zero run of p; mode 2: all zero
    function automatic bit pat_bit(input int mode, input int p, input int i);
        if (mode == 0) return (i % 4 == 0) && (i / 4 < p);
        if (mode == 1) return i < (128 - p);
        return 1'b0;
    endfunction

    // one symbol over two cycles; idle cycle may carry a stray pulse flag
    task automatic send_sym(input bit b, input bit keep, input bit noise);
        @(negedge clk);
        sym_en = 1'b1; sym_pulse = b; amp_pulse = keep | b;
        @(negedge clk);
        sym_en = 1'b0; sym_pulse = noise; amp_pulse = keep;
    endtask

    task automatic run_window(input string req, input int mode, input int p,
                              input bit noise);
        int  ones = 0;
        int  run = 0;
        int  maxrun = 0;
        bit  pass;
        logic start = los;
        for (int i = 0; i < 128; i++) begin
            bit b = pat_bit(mode, p, i);
            if (b) begin ones++; run = 0; end
            else begin run++; if (run > maxrun) maxrun = run; end
            if (i == 127) check("R4 los held inside window", los, start);
            send_sym(b, 1'b1, noise);
        end
        @(negedge clk);
        sym_pulse = 1'b0;
        pass = (ones >= 26) && (maxrun < 64);
        check(req, los, start & ~pass);
    endtask

    task automatic redeclare();
        amp_pulse = 1'b0;
        repeat (130) @(negedge clk);
        check("R2 redeclare", los, 1'b1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 los after reset", los, 1'b1);
        check("R9 squelch after reset", squelch, 1'b1);

        // R5: density sweep, zero runs stay short
        for (int k = 20; k <= 30; k++) begin
            if (!los) redeclare();
            run_window("R5 ones density", 0, k, 1'b0);
        end
        // R6: zero-run sweep with ample ones
        for (int r = 60; r <= 66; r++) begin
            if (!los) redeclare();
            run_window("R6 zero run", 1, r, 1'b0);
        end
        // R7: failing window then passing window back to back
        if (!los) redeclare();
        run_window("R7 failing window", 0, 25, 1'b0);
        check("R7 still lost", los, 1'b1);
        run_window("R7 next window", 0, 26, 1'b0);
        check("R7 cleared by fresh window", los, 1'b0);
        // R8: failing window while clear
        run_window("R8 window cannot declare", 2, 0, 1'b0);
        check("R8 los stays clear", los, 1'b0);
        // R4: stray pulse flags on idle cycles are not counted
        redeclare();
        run_window("R4 idle flags ignored", 0, 25, 1'b1);
        check("R4 25 ones with noise", los, 1'b1);
        run_window("R4 clear", 0, 30, 1'b1);
        // R3: a single pulse restarts the absence count
        amp_pulse = 1'b0;
        repeat (127) @(negedge clk);
        amp_pulse = 1'b1;
        @(negedge clk);
        amp_pulse = 1'b0;
        repeat (127) @(negedge clk);
        check("R3 restart by pulse", los, 1'b0);
        // R2: exact declaration edge
        amp_pulse = 1'b1;
        @(negedge clk);
        amp_pulse = 1'b0;
        repeat (128) @(negedge clk);
        check("R2 not yet after 128", los, 1'b0);
        @(negedge clk);
        check("R2 declared after 129", los, 1'b1);
        // R9: squelch control
        check("R9 squelch with los", squelch, 1'b1);
        squelch_dis = 1'b1;
        #1;
        check("R9 squelch disabled", squelch, 1'b0);
        squelch_dis = 1'b0;
        #1;
        check("R9 squelch enabled", squelch, 1'b1);
        run_window("R9 clear", 0, 32, 1'b0);
        check("R9 no squelch when clear", squelch, 1'b0);

        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(4 * 150000);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule